// File: doc/BRIEF.md
# Wait-For-Interrupt Trap Router

This block decides what happens when a core retires one of its low-power hint instructions: wait-for-interrupt, wait-for-event, or the plain yield hint. It looks at the current exception level, the security state, whether the highest level runs with 64-bit registers, and whether the core has the v8 feature set. It also takes the wait-for-interrupt trap controls from the EL1 and EL3 system-control registers, the hypervisor configuration register and the secure configuration register, and a pending-work indication. From these it works out whether the instruction is trapped and to which level.

A trapped wait-for-interrupt becomes an undefined-instruction request that carries the target level and a fixed syndrome word. An untrapped one becomes a halt request. If work is already pending, it retires with no request at all. Wait-for-event and yield never trap; each produces only a yield request.

The response is registered. It appears one cycle after the instruction strobe and lasts one cycle. The register files and exception entry are outside the block.

Top module: `wfx_trap_router`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, every output is zero.
- R2: A response appears exactly one cycle after a cycle with `ins_valid` high, with `out_valid` high for that cycle. After a cycle with `ins_valid` low, every output is zero.
- R3: For wait-for-interrupt on a v8 core at level 0, the block checks `el1_wfi_allow` unless R4 applies. When that bit is low, the instruction traps to level 1. A core without v8 skips this check.
- R4: At level 0 on a v8 core in the secure state, with `el3_aa64` low, the block checks `el3_wfi_allow` instead. When that bit is low, the instruction traps to level 3.
- R5: If R3 and R4 give no trap, the current level is below 2, the state is non-secure and `hyp_wfi_trap` is high, the instruction traps to level 2.
- R6: If no earlier rule traps, the current level is below 3 and `sec_wfi_trap` is high, the instruction traps to level 3. At level 3 the instruction never traps.
- R7: A wait-for-interrupt with `work_pending` high raises neither halt nor undefined-instruction, whatever the trap controls say.
- R8: A trapped wait-for-interrupt raises `undef_req` with `trap_el` set to the target (1 to 3). Its `syndrome` is 32'h07E0_0000: class 6'h01 in bits 31:26, length bit 25 set, condition-valid bit 24 set, condition 4'hE in bits 23:20, and bit 0 (0 means wait-for-interrupt). An untrapped one raises `halt_req`.
- R9: The `hint` codes are: 2'b00 wait-for-interrupt, 2'b01 wait-for-event, 2'b10 yield, 2'b11 reserved. Codes 2'b01 and 2'b10 raise only `yield_req`, whatever the trap controls and pending work are.
- R10: Code 2'b11 raises `out_valid` with no request.
- R11: At most one of `undef_req`, `halt_req` and `yield_req` is high in any cycle. `trap_el` and `syndrome` are zero whenever `undef_req` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ins_valid | input | 1 | A hint instruction retires this cycle |
| hint | input | 2 | Hint code (see R9) |
| cur_el | input | 2 | Current exception level |
| secure | input | 1 | Secure state |
| el3_aa64 | input | 1 | Level 3 uses 64-bit registers |
| has_v8 | input | 1 | Core implements the v8 feature set |
| el1_wfi_allow | input | 1 | EL1 system-control negative-sense trap bit (1 = allowed) |
| el3_wfi_allow | input | 1 | EL3 system-control negative-sense trap bit (1 = allowed) |
| hyp_wfi_trap | input | 1 | Hypervisor configuration trap bit |
| sec_wfi_trap | input | 1 | Secure configuration trap bit |
| work_pending | input | 1 | Core already has work to do |
| out_valid | output | 1 | Registered response valid |
| undef_req | output | 1 | Undefined-instruction exception request |
| halt_req | output | 1 | Halt request |
| yield_req | output | 1 | Yield request |
| trap_el | output | 2 | Trap target level, 0 when not trapped |
| syndrome | output | 32 | Syndrome for the undefined-instruction request |

## Verification
The assertions assume that every input is known and stable around the clock edge of a cycle with `ins_valid` high. They do not assume that the level and the security state form an architecturally legal pair; each rule is checked on its own conditions. The stimulus meets these assumptions by driving all inputs on the falling edge. It sweeps every combination of hint code, level, security state, register width, feature flag, trap bit and pending work, including pairs such as secure level 2 that a real core never presents. Idle cycles are placed between strobes so that both back-to-back and isolated responses occur.

// File: rtl/wfx_pkg.sv
package wfx_pkg;

    localparam int EL_W  = 2;
    localparam int SYN_W = 32;

    // syndrome field layout
    localparam int        EC_LSB   = 26;
    localparam int        EC_W     = 6;
    localparam int        IL_BIT   = 25;
    localparam int        CV_BIT   = 24;
    localparam int        COND_LSB = 20;
    localparam int        COND_W   = 4;
    localparam logic [EC_W-1:0]   EC_WFX  = 6'h01;
    localparam logic [COND_W-1:0] COND_AL = 4'hE;

    typedef enum logic [1:0] {
        HINT_WFI   = 2'd0,
        HINT_WFE   = 2'd1,
        HINT_YIELD = 2'd2,
        HINT_RSVD  = 2'd3
    } hint_e;

    typedef struct packed {
        logic             vld;
        logic             undef;
        logic             halt;
        logic             yld;
        logic [EL_W-1:0]  tgt;
        logic [SYN_W-1:0] syn;
    } resp_t;

endpackage

// File: rtl/wfx_trap_select.sv
module wfx_trap_select
    import wfx_pkg::*;
(
    input  logic [EL_W-1:0] cur_el,
    input  logic            secure,
    input  logic            el3_aa64,
    input  logic            has_v8,
    input  logic            el1_wfi_allow,
    input  logic            el3_wfi_allow,
    input  logic            hyp_wfi_trap,
    input  logic            sec_wfi_trap,
    output logic [EL_W-1:0] tgt
);
    localparam logic [EL_W-1:0] LVL0 = EL_W'(0);
    localparam logic [EL_W-1:0] LVL1 = EL_W'(1);
    localparam logic [EL_W-1:0] LVL2 = EL_W'(2);
    localparam logic [EL_W-1:0] LVL3 = EL_W'(3);

    logic            sctl_hit;
    logic [EL_W-1:0] sctl_lvl;

    // first stage: system-control check at level 0
    always_comb begin
        sctl_hit = 1'b0;
        sctl_lvl = LVL1;
        if (cur_el == LVL0 && has_v8) begin
            if (secure && !el3_aa64) begin
                sctl_lvl = LVL3;
                sctl_hit = !el3_wfi_allow;
            end else begin
                sctl_lvl = LVL1;
                sctl_hit = !el1_wfi_allow;
            end
        end
    end

    // priority chain across the three control registers
    always_comb begin
        tgt = LVL0;
        if (sctl_hit) begin
            tgt = sctl_lvl;
        end else if (cur_el < LVL2 && !secure && hyp_wfi_trap) begin
            tgt = LVL2;
        end else if (cur_el < LVL3 && sec_wfi_trap) begin
            tgt = LVL3;
        end
    end

endmodule

// File: rtl/wfx_syndrome_gen.sv
module wfx_syndrome_gen
    import wfx_pkg::*;
(
    input  logic             is_wfe,
    output logic [SYN_W-1:0] syn
);
    always_comb begin
        syn = '0;
        syn[EC_LSB +: EC_W]     = EC_WFX;
        syn[IL_BIT]             = 1'b1;
        syn[CV_BIT]             = 1'b1;
        syn[COND_LSB +: COND_W] = COND_AL;
        syn[0]                  = is_wfe;
    end
endmodule

// File: rtl/wfx_trap_router.sv
module wfx_trap_router
    import wfx_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ins_valid,
    input  logic [1:0]       hint,
    input  logic [EL_W-1:0]  cur_el,
    input  logic             secure,
    input  logic             el3_aa64,
    input  logic             has_v8,
    input  logic             el1_wfi_allow,
    input  logic             el3_wfi_allow,
    input  logic             hyp_wfi_trap,
    input  logic             sec_wfi_trap,
    input  logic             work_pending,
    output logic             out_valid,
    output logic             undef_req,
    output logic             halt_req,
    output logic             yield_req,
    output logic [EL_W-1:0]  trap_el,
    output logic [SYN_W-1:0] syndrome
);
    logic [EL_W-1:0]  tgt;
    logic [SYN_W-1:0] wfi_syn;
    hint_e            kind;
    resp_t            resp_d, resp_q;

    assign kind = hint_e'(hint);

    wfx_trap_select u_sel (
        .cur_el        (cur_el),
        .secure        (secure),
        .el3_aa64      (el3_aa64),
        .has_v8        (has_v8),
        .el1_wfi_allow (el1_wfi_allow),
        .el3_wfi_allow (el3_wfi_allow),
        .hyp_wfi_trap  (hyp_wfi_trap),
        .sec_wfi_trap  (sec_wfi_trap),
        .tgt           (tgt)
    );

    wfx_syndrome_gen u_syn (
        .is_wfe (1'b0),
        .syn    (wfi_syn)
    );

    always_comb begin
        resp_d = '0;
        if (ins_valid) begin
            resp_d.vld = 1'b1;
            unique case (kind)
                HINT_WFI: begin
                    if (!work_pending) begin
                        if (tgt != '0) begin
                            resp_d.undef = 1'b1;
                            resp_d.tgt   = tgt;
                            resp_d.syn   = wfi_syn;
                        end else begin
                            resp_d.halt = 1'b1;
                        end
                    end
                end
                HINT_WFE, HINT_YIELD: resp_d.yld = 1'b1;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            resp_q <= '0;
        end else begin
            resp_q <= resp_d;
        end
    end

    assign out_valid = resp_q.vld;
    assign undef_req = resp_q.undef;
    assign halt_req  = resp_q.halt;
    assign yield_req = resp_q.yld;
    assign trap_el   = resp_q.tgt;
    assign syndrome  = resp_q.syn;

endmodule

// File: rtl/wfx_trap_router_chk.sv
module wfx_trap_router_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        ins_valid,
    input logic [1:0]  hint,
    input logic [1:0]  cur_el,
    input logic        secure,
    input logic        el3_aa64,
    input logic        has_v8,
    input logic        el3_wfi_allow,
    input logic        work_pending,
    input logic        out_valid,
    input logic        undef_req,
    input logic        halt_req,
    input logic        yield_req,
    input logic [1:0]  trap_el,
    input logic [31:0] syndrome
);
    // R2: response follows the strobe by one cycle
    p_resp_follows_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ins_valid |=> out_valid);
    p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !ins_valid |=> !out_valid && !undef_req && !halt_req && !yield_req);

    // R4: secure level 0 with 32-bit EL3 routes to level 3
    p_secure_el0_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ins_valid && hint == 2'd0 && !work_pending && cur_el == 2'd0 && has_v8
        && secure && !el3_aa64 && !el3_wfi_allow |=> undef_req && trap_el == 2'd3);

    // R6: level 3 never traps
    p_el3_no_trap_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ins_valid && cur_el == 2'd3 |=> !undef_req);

    // R7: pending work suppresses halt and trap
    p_pending_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ins_valid && hint == 2'd0 && work_pending |=> !undef_req && !halt_req);

    // R8: syndrome word of a trapped instruction
    p_syndrome_r8: assert property (@(posedge clk) disable iff (!rst_n)
        undef_req |-> syndrome == 32'h07E0_0000 && trap_el != 2'd0);

    // R9: event and yield hints only yield
    p_yield_only_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ins_valid && (hint == 2'd1 || hint == 2'd2) |=> yield_req && !undef_req && !halt_req);

    // R10: reserved code gives no request
    p_reserved_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ins_valid && hint == 2'd3 |=> out_valid && !undef_req && !halt_req && !yield_req);

    // R11: exclusive requests, quiet side fields
    p_exclusive_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({undef_req, halt_req, yield_req}));
    p_side_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !undef_req |-> trap_el == 2'd0 && syndrome == 32'd0);

endmodule

bind wfx_trap_router wfx_trap_router_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .ins_valid     (ins_valid),
    .hint          (hint),
    .cur_el        (cur_el),
    .secure        (secure),
    .el3_aa64      (el3_aa64),
    .has_v8        (has_v8),
    .el3_wfi_allow (el3_wfi_allow),
    .work_pending  (work_pending),
    .out_valid     (out_valid),
    .undef_req     (undef_req),
    .halt_req      (halt_req),
    .yield_req     (yield_req),
    .trap_el       (trap_el),
    .syndrome      (syndrome)
);

// File: tb/wfx_trap_router_tb.sv
module wfx_trap_router_tb;
    localparam real HALF = 2.5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ins_valid = 1'b0;
    logic [1:0]  hint = '0;
    logic [1:0]  cur_el = '0;
    logic        secure = 1'b0, el3_aa64 = 1'b0, has_v8 = 1'b0;
    logic        el1_wfi_allow = 1'b0, el3_wfi_allow = 1'b0;
    logic        hyp_wfi_trap = 1'b0, sec_wfi_trap = 1'b0, work_pending = 1'b0;
    logic        out_valid, undef_req, halt_req, yield_req;
    logic [1:0]  trap_el;
    logic [31:0] syndrome;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #(HALF) clk = ~clk;

    wfx_trap_router u_dut (
        .clk(clk), .rst_n(rst_n), .ins_valid(ins_valid), .hint(hint),
        .cur_el(cur_el), .secure(secure), .el3_aa64(el3_aa64), .has_v8(has_v8),
        .el1_wfi_allow(el1_wfi_allow), .el3_wfi_allow(el3_wfi_allow),
        .hyp_wfi_trap(hyp_wfi_trap), .sec_wfi_trap(sec_wfi_trap),
        .work_pending(work_pending), .out_valid(out_valid), .undef_req(undef_req),
        .halt_req(halt_req), .yield_req(yield_req), .trap_el(trap_el),
        .syndrome(syndrome)
    );

    // expected = {vld, undef, halt, yield, trap_el[1:0], syndrome[31:0]}
    function automatic logic [37:0] model(output string tag);
        int lvl;
        lvl = 0;
        tag = "R2";
        if (!ins_valid) return 38'd0;
        if (hint == 2'd3) begin
            tag = "R10";
            return {1'b1, 37'd0};
        end
        if (hint != 2'd0) begin
            tag = "R9";
            return {4'b1001, 34'd0};
        end
        if (work_pending) begin
            tag = "R7";
            return {1'b1, 37'd0};
        end
        tag = "R8";
        if (cur_el == 0 && has_v8) begin
            if (secure && !el3_aa64) begin
                if (!el3_wfi_allow) begin lvl = 3; tag = "R4"; end
            end else if (!el1_wfi_allow) begin
                lvl = 1; tag = "R3";
            end
        end
        if (lvl == 0 && cur_el < 2 && !secure && hyp_wfi_trap) begin
            lvl = 2; tag = "R5";
        end
        if (lvl == 0 && cur_el < 3 && sec_wfi_trap) begin
            lvl = 3; tag = "R6";
        end
        if (lvl == 0) return {4'b1010, 34'd0};
        return {4'b1100, 2'(lvl), 32'h07E0_0000};
    endfunction

    task automatic compare(input logic [37:0] exp, input string tag);
        logic [37:0] act;
        act = {out_valid, undef_req, halt_req, yield_req, trap_el, syndrome};
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
        n_checks++;
        if ($countones({undef_req, halt_req, yield_req}) > 1) begin
            n_fail++;
            $display("FAIL R11: actual requests %b expected at most one",
                     {undef_req, halt_req, yield_req});
        end
    endtask

    initial begin
        #(HALF * 2.0 * 200000.0);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        logic [37:0] exp;
        string       tag;
        // R1: outputs held at zero in reset, even with a strobe
        ins_valid = 1'b1;
        repeat (3) @(posedge clk);
        #1 compare(38'd0, "R1");
        @(negedge clk);
        ins_valid = 1'b0;
        rst_n = 1'b1;
        @(posedge clk);
        #1 compare(38'd0, "R1");

        for (int i = 0; i < 4096; i++) begin
            @(negedge clk);
            ins_valid     = (i % 5) != 4;
            {hint, cur_el, secure, el3_aa64, has_v8, el1_wfi_allow,
             el3_wfi_allow, hyp_wfi_trap, sec_wfi_trap, work_pending} = 12'(i * 7 + i / 512);
            exp = model(tag);
            @(posedge clk);
            #1 compare(exp, tag);
        end

        // exhaustive pass without gaps
        for (int i = 0; i < 4096; i++) begin
            @(negedge clk);
            ins_valid = 1'b1;
            {hint, cur_el, secure, el3_aa64, has_v8, el1_wfi_allow,
             el3_wfi_allow, hyp_wfi_trap, sec_wfi_trap, work_pending} = 12'(i);
            exp = model(tag);
            @(posedge clk);
            #1 compare(exp, tag);
        end

        // R2: quiet after strobe drops
        @(negedge clk);
        ins_valid = 1'b0;
        @(posedge clk);
        #1 compare(38'd0, "R2");

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule